// File: doc/BRIEF.md
# Calibration Sequencer Control Arbiter

This block holds the memory-side command path from the moment the interface is reset until calibration concludes. While it holds that path, the commands sent to memory come from the calibration workers. The normal memory controller is kept out and sees its ready signal held low. The block steps through three calibration stages in a fixed order: memory initialisation, the search for the read-valid FIFO setting, and the search for the latency FIFO setting. Each stage is a request/acknowledge handshake with an external worker.

When all three stages succeed, the block shows a pass status and hands the command path to the controller for good. An error in any stage sends it to a fail state that only reset can leave, and the controller is never admitted from that state. On the PHY side, the block raises a sticky flag when memory initialisation completes. It also writes each FIFO setting found by a search stage into a PHY register through a single-cycle write port.

Top module: `calseq_arbiter`

## Requirements
- R1: While reset is high, and in the cycle that samples it, `wk_go`, `init_done`, `cal_pass`, `cal_fail`, `preg_we` and `ctl_cmd_ready` are all low.
- R2: From the first clock edge after reset is released, `wk_go` is one-hot with bit 0 = initialisation, bit 1 = read-valid FIFO search and bit 2 = latency FIFO search. The stages run strictly in that order, and each bit stays high until a `wk_done` or `wk_err` pulse ends its stage.
- R3: A `wk_err` pulse during a stage moves the block at the next edge into a fail state: `cal_fail` high, `wk_go` zero. `wk_err` wins over a `wk_done` in the same cycle. The fail state persists until reset.
- R4: Until calibration passes, the memory command outputs carry the worker command, and `ctl_cmd_ready` is 0 whatever the controller drives. Outside the three stages (during reset and in the fail state), `mem_cmd_valid` is forced to 0.
- R5: Once calibration passes, the memory command outputs carry the controller command (valid, code, address), `ctl_cmd_ready` is 1, and the worker command has no effect.
- R6: `init_done` rises at the edge that accepts a successful `wk_done` from the initialisation stage. It stays high until reset, even if a later stage fails.
- R7: At the edge that completes the read-valid search, a one-cycle PHY write is issued with `preg_addr` = `RDV_REG_ADDR` (default 2). At the edge that completes the latency search, a write is issued with `preg_addr` = `LAT_REG_ADDR` (default 3). In both cases `preg_wdata` equals the `wk_result` presented with that `wk_done`. No write is issued for the initialisation stage or for a stage that ends in error.
- R8: `cal_pass` and `cal_fail` are never high together. Both stay low until the final stage or an error ends calibration. `cal_pass` rises at the edge that completes the latency search.
- R9: A reset asserted at any point, whether mid-stage, after a pass or after a fail, clears every status and takes the command path back from the controller at the next edge. After release, calibration restarts at initialisation.
- R10: `wk_done` and `wk_err` pulses are ignored while the block is in the pass or fail state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wk_go | output | 3 | One-hot stage request to the calibration workers |
| wk_done | input | 1 | Stage completed successfully (pulse) |
| wk_err | input | 1 | Stage failed (pulse) |
| wk_result | input | RES_W | Setting found by the current search stage, valid with `wk_done` |
| wk_cmd_valid | input | 1 | Worker command valid |
| wk_cmd_code | input | 4 | Worker command code |
| wk_cmd_addr | input | 14 | Worker command address |
| ctl_cmd_valid | input | 1 | Controller command valid |
| ctl_cmd_code | input | 4 | Controller command code |
| ctl_cmd_addr | input | 14 | Controller command address |
| ctl_cmd_ready | output | 1 | Controller command accepted; high only after a pass |
| mem_cmd_valid | output | 1 | Command valid toward memory |
| mem_cmd_code | output | 4 | Command code toward memory |
| mem_cmd_addr | output | 14 | Command address toward memory |
| init_done | output | 1 | Memory initialisation complete (sticky) |
| cal_pass | output | 1 | Calibration passed |
| cal_fail | output | 1 | Calibration failed |
| preg_we | output | 1 | PHY register write strobe |
| preg_addr | output | PREG_AW | PHY register address |
| preg_wdata | output | RES_W | PHY register write data |

## Verification
The bench covers every outcome: an error in each of the three stages, and a full pass. An error is sent both alone and together with a done pulse, which tells apart a design that lets done win a collision from one that lets error win. Each stage is held for zero, one or two idle cycles before its pulse, so that a stage request that drops early, or a wrongly ordered stage, shows up. The search results differ per run, so the PHY write data and addresses can be matched to the correct stage. Controller and worker commands are driven with different codes at every phase, which exposes any leak through the multiplexer. A separate run resets the block in the middle of a stage to confirm that calibration restarts.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CMD_CODE_W = 4;
    localparam int CMD_ADDR_W = 14;
    localparam int NUM_STAGES = 3;

    typedef enum logic [2:0] {
        CS_HOLD,
        CS_INIT,
        CS_RDV,
        CS_LAT,
        CS_PASS,
        CS_FAIL
    } cal_state_e;

    typedef struct packed {
        logic                  valid;
        logic [CMD_CODE_W-1:0] code;
        logic [CMD_ADDR_W-1:0] addr;
    } mem_cmd_t;

    function automatic logic in_stage(input cal_state_e s);
        return (s == CS_INIT) || (s == CS_RDV) || (s == CS_LAT);
    endfunction

    function automatic logic [NUM_STAGES-1:0] stage_go(input cal_state_e s);
        logic [NUM_STAGES-1:0] g;
        g = '0;
        case (s)
            CS_INIT: g[0] = 1'b1;
            CS_RDV:  g[1] = 1'b1;
            CS_LAT:  g[2] = 1'b1;
            default: g = '0;
        endcase
        return g;
    endfunction

    function automatic cal_state_e stage_after(input cal_state_e s);
        case (s)
            CS_INIT: return CS_RDV;
            CS_RDV:  return CS_LAT;
            CS_LAT:  return CS_PASS;
            default: return s;
        endcase
    endfunction
endpackage

// File: rtl/calseq_fsm.sv
module calseq_fsm
    import calseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wk_done,
    input  logic       wk_err,
    output cal_state_e state,
    output logic       step_ok
);
    timeunit 1ns;
    timeprecision 1ps;

    cal_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (in_stage(state_q)) begin
            if (wk_err)
                state_d = CS_FAIL;
            else if (wk_done)
                state_d = stage_after(state_q);
        end else if (state_q == CS_HOLD) begin
            state_d = CS_INIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= CS_HOLD;
        else
            state_q <= state_d;
    end

    assign state   = state_q;
    assign step_ok = in_stage(state_q) && wk_done && !wk_err;

    AST_ORDER_RDV: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_RDV) |-> ($past(state_q) == CS_INIT || $past(state_q) == CS_RDV)); // R2
    AST_ORDER_LAT: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_LAT) |-> ($past(state_q) == CS_RDV || $past(state_q) == CS_LAT)); // R2
    AST_ORDER_PASS: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_PASS) |-> ($past(state_q) == CS_LAT || $past(state_q) == CS_PASS)); // R8
    AST_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
        (in_stage(state_q) && wk_err) |=> (state_q == CS_FAIL)); // R3
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_FAIL) |=> (state_q == CS_FAIL)); // R3
    AST_PASS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_PASS) |=> (state_q == CS_PASS)); // R10
endmodule

// File: rtl/calseq_status.sv
module calseq_status
    import calseq_pkg::*;
#(
    parameter int               RES_W        = 6,
    parameter int               PREG_AW      = 4,
    parameter logic [PREG_AW-1:0] RDV_REG_ADDR = 4'd2,
    parameter logic [PREG_AW-1:0] LAT_REG_ADDR = 4'd3
) (
    input  logic               clk,
    input  logic               rst,
    input  cal_state_e         state,
    input  logic               step_ok,
    input  logic [RES_W-1:0]   wk_result,
    output logic               init_done,
    output logic               cal_pass,
    output logic               cal_fail,
    output logic               preg_we,
    output logic [PREG_AW-1:0] preg_addr,
    output logic [RES_W-1:0]   preg_wdata
);
    timeunit 1ns;
    timeprecision 1ps;

    logic search_ok;
    assign search_ok = step_ok && ((state == CS_RDV) || (state == CS_LAT));

    always_ff @(posedge clk) begin
        if (rst) begin
            init_done  <= 1'b0;
            preg_we    <= 1'b0;
            preg_addr  <= '0;
            preg_wdata <= '0;
        end else begin
            if (step_ok && state == CS_INIT)
                init_done <= 1'b1;
            preg_we <= search_ok;
            if (search_ok) begin
                preg_addr  <= (state == CS_RDV) ? RDV_REG_ADDR : LAT_REG_ADDR;
                preg_wdata <= wk_result;
            end
        end
    end

    assign cal_pass = (state == CS_PASS);
    assign cal_fail = (state == CS_FAIL);

    AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cal_pass && cal_fail)); // R8
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R6
    AST_PREG_ADDR: assert property (@(posedge clk) disable iff (rst)
        preg_we |-> (preg_addr == RDV_REG_ADDR || preg_addr == LAT_REG_ADDR)); // R7
    AST_PREG_PULSE: assert property (@(posedge clk) disable iff (rst)
        (preg_we && preg_addr == LAT_REG_ADDR) |=> !preg_we); // R7
endmodule

// File: rtl/calseq_cmd_mux.sv
module calseq_cmd_mux
    import calseq_pkg::*;
(
    input  logic     ctl_owner,
    input  logic     seq_live,
    input  mem_cmd_t wk_cmd,
    input  mem_cmd_t ctl_cmd,
    output mem_cmd_t mem_cmd,
    output logic     ctl_ready
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        if (ctl_owner) begin
            mem_cmd   = ctl_cmd;
            ctl_ready = 1'b1;
        end else begin
            mem_cmd       = wk_cmd;
            mem_cmd.valid = wk_cmd.valid && seq_live;
            ctl_ready     = 1'b0;
        end
    end
endmodule

// File: rtl/calseq_arbiter.sv
module calseq_arbiter
    import calseq_pkg::*;
#(
    parameter int               RES_W        = 6,
    parameter int               PREG_AW      = 4,
    parameter logic [PREG_AW-1:0] RDV_REG_ADDR = 4'd2,
    parameter logic [PREG_AW-1:0] LAT_REG_ADDR = 4'd3
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [NUM_STAGES-1:0] wk_go,
    input  logic                  wk_done,
    input  logic                  wk_err,
    input  logic [RES_W-1:0]      wk_result,
    input  logic                  wk_cmd_valid,
    input  logic [CMD_CODE_W-1:0] wk_cmd_code,
    input  logic [CMD_ADDR_W-1:0] wk_cmd_addr,
    input  logic                  ctl_cmd_valid,
    input  logic [CMD_CODE_W-1:0] ctl_cmd_code,
    input  logic [CMD_ADDR_W-1:0] ctl_cmd_addr,
    output logic                  ctl_cmd_ready,
    output logic                  mem_cmd_valid,
    output logic [CMD_CODE_W-1:0] mem_cmd_code,
    output logic [CMD_ADDR_W-1:0] mem_cmd_addr,
    output logic                  init_done,
    output logic                  cal_pass,
    output logic                  cal_fail,
    output logic                  preg_we,
    output logic [PREG_AW-1:0]    preg_addr,
    output logic [RES_W-1:0]      preg_wdata
);
    timeunit 1ns;
    timeprecision 1ps;

    cal_state_e state;
    logic       step_ok;
    mem_cmd_t   wk_cmd, ctl_cmd, mem_cmd;

    calseq_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .wk_done (wk_done),
        .wk_err  (wk_err),
        .state   (state),
        .step_ok (step_ok)
    );

    calseq_status #(
        .RES_W        (RES_W),
        .PREG_AW      (PREG_AW),
        .RDV_REG_ADDR (RDV_REG_ADDR),
        .LAT_REG_ADDR (LAT_REG_ADDR)
    ) i_status (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .step_ok    (step_ok),
        .wk_result  (wk_result),
        .init_done  (init_done),
        .cal_pass   (cal_pass),
        .cal_fail   (cal_fail),
        .preg_we    (preg_we),
        .preg_addr  (preg_addr),
        .preg_wdata (preg_wdata)
    );

    assign wk_cmd  = '{valid: wk_cmd_valid,  code: wk_cmd_code,  addr: wk_cmd_addr};
    assign ctl_cmd = '{valid: ctl_cmd_valid, code: ctl_cmd_code, addr: ctl_cmd_addr};

    calseq_cmd_mux i_mux (
        .ctl_owner (cal_pass),
        .seq_live  (in_stage(state)),
        .wk_cmd    (wk_cmd),
        .ctl_cmd   (ctl_cmd),
        .mem_cmd   (mem_cmd),
        .ctl_ready (ctl_cmd_ready)
    );

    assign mem_cmd_valid = mem_cmd.valid;
    assign mem_cmd_code  = mem_cmd.code;
    assign mem_cmd_addr  = mem_cmd.addr;
    assign wk_go         = stage_go(state);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cal_pass && !cal_fail && !ctl_cmd_ready && !init_done && !preg_we)); // R1
    AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wk_go)); // R2
    AST_CTL_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        ctl_cmd_ready |-> cal_pass); // R5
    AST_SEQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (!cal_pass && mem_cmd_valid) |-> (wk_cmd_valid && mem_cmd_code == wk_cmd_code)); // R4
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
        cal_fail |-> (!mem_cmd_valid && !ctl_cmd_ready && wk_go == '0)); // R4
endmodule

// File: tb/test_calseq_arbiter.sv
module test_calseq_arbiter;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  wk_go;
    logic        wk_done = 1'b0, wk_err = 1'b0;
    logic [5:0]  wk_result = '0;
    logic        wk_cmd_valid = 1'b0;
    logic [3:0]  wk_cmd_code = '0;
    logic [13:0] wk_cmd_addr = '0;
    logic        ctl_cmd_valid = 1'b0;
    logic [3:0]  ctl_cmd_code = '0;
    logic [13:0] ctl_cmd_addr = '0;
    logic        ctl_cmd_ready, mem_cmd_valid;
    logic [3:0]  mem_cmd_code;
    logic [13:0] mem_cmd_addr;
    logic        init_done, cal_pass, cal_fail, preg_we;
    logic [3:0]  preg_addr;
    logic [5:0]  preg_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    calseq_arbiter i_calseq_arbiter (
        .clk(clk), .rst(rst), .wk_go(wk_go), .wk_done(wk_done), .wk_err(wk_err),
        .wk_result(wk_result), .wk_cmd_valid(wk_cmd_valid), .wk_cmd_code(wk_cmd_code),
        .wk_cmd_addr(wk_cmd_addr), .ctl_cmd_valid(ctl_cmd_valid), .ctl_cmd_code(ctl_cmd_code),
        .ctl_cmd_addr(ctl_cmd_addr), .ctl_cmd_ready(ctl_cmd_ready), .mem_cmd_valid(mem_cmd_valid),
        .mem_cmd_code(mem_cmd_code), .mem_cmd_addr(mem_cmd_addr), .init_done(init_done),
        .cal_pass(cal_pass), .cal_fail(cal_fail), .preg_we(preg_we), .preg_addr(preg_addr),
        .preg_wdata(preg_wdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic quiet_inputs();
        wk_done = 1'b0; wk_err = 1'b0; wk_cmd_valid = 1'b0; ctl_cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        quiet_inputs();
        rst = 1'b1;
        nxt(); nxt();
        chk("R1", "go", {29'd0, wk_go}, 32'd0);
        chk("R1", "ready", {31'd0, ctl_cmd_ready}, 32'd0);
        chk("R1", "pass", {31'd0, cal_pass}, 32'd0);
        chk("R1", "fail", {31'd0, cal_fail}, 32'd0);
        chk("R1", "init_done", {31'd0, init_done}, 32'd0);
        chk("R1", "preg_we", {31'd0, preg_we}, 32'd0);
        rst = 1'b0;
        nxt();
    endtask

    // fstage 0..2 = stage that errors, 3 = full pass
    task automatic run(input int fstage, input bit both, input int dly, input int seed);
        bit failed = 1'b0;
        logic [5:0] res;
        do_reset();
        for (int s = 0; s < 3; s++) begin
            if (!failed) begin
                for (int d = 0; d < dly; d++) begin
                    wk_cmd_valid = 1'b1; wk_cmd_code = 4'(s + d + 1); wk_cmd_addr = 14'(seed * 5 + s);
                    ctl_cmd_valid = 1'b1; ctl_cmd_code = 4'hF; ctl_cmd_addr = 14'h3FFF;
                    #1;
                    chk("R2", "go held", {29'd0, wk_go}, 32'(1 << s));
                    chk("R4", "mem valid", {31'd0, mem_cmd_valid}, 32'd1);
                    chk("R4", "mem code", {28'd0, mem_cmd_code}, {28'd0, wk_cmd_code});
                    chk("R4", "mem addr", {18'd0, mem_cmd_addr}, {18'd0, wk_cmd_addr});
                    chk("R4", "ready", {31'd0, ctl_cmd_ready}, 32'd0);
                    nxt();
                end
                chk("R2", "go", {29'd0, wk_go}, 32'(1 << s));
                if (s == 0) chk("R6", "init before", {31'd0, init_done}, 32'd0);
                chk("R8", "pass early", {31'd0, cal_pass}, 32'd0);
                res = 6'((seed * 13 + s * 7 + 3) & 63);
                wk_result = res;
                if (s == fstage) begin
                    wk_err = 1'b1; wk_done = both;
                end else begin
                    wk_done = 1'b1;
                end
                nxt();
                quiet_inputs();
                if (s == fstage) begin
                    failed = 1'b1;
                    chk("R3", "fail", {31'd0, cal_fail}, 32'd1);
                    chk("R8", "pass on fail", {31'd0, cal_pass}, 32'd0);
                    chk("R3", "go cleared", {29'd0, wk_go}, 32'd0);
                    chk("R7", "no write on err", {31'd0, preg_we}, 32'd0);
                end else begin
                    chk("R2", "go next", {29'd0, wk_go}, (s < 2) ? 32'(1 << (s + 1)) : 32'd0);
                    chk("R6", "init_done", {31'd0, init_done}, 32'd1);
                    chk("R7", "write strobe", {31'd0, preg_we}, (s >= 1) ? 32'd1 : 32'd0);
                    if (s >= 1) begin
                        chk("R7", "write addr", {28'd0, preg_addr}, (s == 1) ? 32'd2 : 32'd3);
                        chk("R7", "write data", {26'd0, preg_wdata}, {26'd0, res});
                    end
                    chk("R8", "pass", {31'd0, cal_pass}, (s == 2) ? 32'd1 : 32'd0);
                    chk("R8", "fail", {31'd0, cal_fail}, 32'd0);
                end
            end
        end
        if (failed) begin
            for (int k = 0; k < 3; k++) begin
                wk_done = 1'b1; wk_cmd_valid = 1'b1; wk_cmd_code = 4'(k + 2);
                ctl_cmd_valid = 1'b1; ctl_cmd_code = 4'hE;
                #1;
                chk("R4", "mem valid in fail", {31'd0, mem_cmd_valid}, 32'd0);
                chk("R5", "no grant in fail", {31'd0, ctl_cmd_ready}, 32'd0);
                nxt();
                quiet_inputs();
                chk("R10", "fail holds", {31'd0, cal_fail}, 32'd1);
                chk("R10", "no pass", {31'd0, cal_pass}, 32'd0);
                chk("R6", "init kept", {31'd0, init_done}, (fstage > 0) ? 32'd1 : 32'd0);
                chk("R10", "go idle", {29'd0, wk_go}, 32'd0);
            end
        end else begin
            nxt();
            chk("R7", "single write", {31'd0, preg_we}, 32'd0);
            ctl_cmd_valid = 1'b1; ctl_cmd_code = 4'(seed + 1); ctl_cmd_addr = 14'(seed * 97);
            wk_cmd_valid = 1'b1; wk_cmd_code = ~4'(seed + 1); wk_cmd_addr = ~14'(seed * 97);
            #1;
            chk("R5", "ready", {31'd0, ctl_cmd_ready}, 32'd1);
            chk("R5", "mem valid", {31'd0, mem_cmd_valid}, 32'd1);
            chk("R5", "mem code", {28'd0, mem_cmd_code}, {28'd0, ctl_cmd_code});
            chk("R5", "mem addr", {18'd0, mem_cmd_addr}, {18'd0, ctl_cmd_addr});
            ctl_cmd_valid = 1'b0;
            #1;
            chk("R5", "worker ignored", {31'd0, mem_cmd_valid}, 32'd0);
            wk_err = 1'b1;
            nxt();
            quiet_inputs();
            chk("R10", "pass holds", {31'd0, cal_pass}, 32'd1);
            chk("R10", "no fail", {31'd0, cal_fail}, 32'd0);
        end
        rst = 1'b1;
        nxt();
        chk("R9", "pass cleared", {31'd0, cal_pass}, 32'd0);
        chk("R9", "fail cleared", {31'd0, cal_fail}, 32'd0);
        chk("R9", "ready cleared", {31'd0, ctl_cmd_ready}, 32'd0);
        chk("R9", "init cleared", {31'd0, init_done}, 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed = 0;
        for (int f = 0; f < 4; f++)
            for (int b = 0; b < 2; b++)
                for (int d = 0; d < 3; d++) begin
                    run(f, b[0], d, seed);
                    seed++;
                end
        // R9: reset in the middle of the read-valid search restarts calibration
        do_reset();
        wk_done = 1'b1;
        nxt();
        quiet_inputs();
        chk("R2", "in search", {29'd0, wk_go}, 32'd2);
        rst = 1'b1;
        nxt();
        chk("R9", "go cleared", {29'd0, wk_go}, 32'd0);
        chk("R9", "init cleared", {31'd0, init_done}, 32'd0);
        rst = 1'b0;
        nxt();
        chk("R9", "restart at init", {29'd0, wk_go}, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule